// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the software-visible register file of an I/O interrupt router. It sits on a simple 32-bit bus slave port with an access-size qualifier. Software first loads a register number into an index register. It then reads or writes a 32-bit data window, and the window reaches the register that the index names. Behind the window are an identifier register, a read-only version register, an arbitration alias of the identifier, and a table of 64-bit routing entries. Each routing entry is reached as two 32-bit halves.

The routing table is exported as a flat vector to the separate servicing logic. That logic owns the two read-only status bits of each entry. It drives a per-pin delivery-status level, and it raises or drops a per-pin "awaiting end-of-interrupt" flag through set and clear strobes. Every accepted table write produces a one-cycle service request, so the servicing logic can re-examine the pins. A directed end-of-interrupt offset exists only in the 0x20 version of the block. A full-word write to it is handed on as a one-cycle strobe carrying the written vector number.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every routing entry reads 0x0000_0000_0001_0000 (mask bit 16 set, all other bits zero). The index register and the identifier are 0, and rdata_o, service_o and eoi_o are 0.
- R2: Only addr_i[7:0] is decoded. A write of any size to offset 0x00 stores wdata_i[7:0] as the index. A read of any size at offset 0x00 returns the index in bits 7:0.
- R3: A data-window access (offset 0x10) whose size_i is not 4 reads 0 and changes no state.
- R4: Index 0x00 is the identifier. A full-word window write stores wdata_i[27:24]. Reads at index 0x00 or 0x02 return the identifier in bits 27:24 and zero elsewhere. Window writes at index 0x01 or 0x02 change nothing.
- R5: A window read at index 0x01 returns VERSION in bits 7:0 and NPINS-1 in bits 23:16 (0x0017_0020 by default). VERSION may only be 0x11 or 0x20.
- R6: An index 0x10+2n with n < NPINS reaches entry n. An even index selects entry bits 31:0 and an odd index selects bits 63:32. Indexes 0x03–0x0F and indexes at or above 0x10+2·NPINS read 0, and writes to them are ignored.
- R7: The software-writable entry bits are 7:0 (vector), 10:8 (delivery mode), 11 (destination mode), 13 (polarity), 15 (trigger, 1 = level), 16 (mask) and 63:48 (destination). Bits 47:17 always read 0.
- R8: Bit 12 (delivery status) follows dlvs_i[n] one cycle later. Bit 14 (awaiting-EOI) is set by rirr_set_i[n] and cleared by rirr_clr_i[n], with clear winning. A software write to the entry leaves both bits unchanged.
- R9: When a table write leaves bit 15 at 0 (edge), bit 14 of that entry is forced to 0 in the same update. This takes priority over rirr_set_i.
- R10: service_o is high for exactly the one cycle after each accepted table write, and is low at all other times.
- R11: With VERSION 0x20, a write of size 4 to offset 0x40 makes eoi_o high for one cycle on the next cycle, with eoi_vec_o equal to wdata_i[7:0]. Other sizes, and any write when VERSION is 0x11, raise nothing.
- R12: rdata_o carries the read result in the cycle after a read request and is 0 in every cycle that follows no read. Unmapped offsets read 0.
- R13: table_o holds entry n at bits 64n+63:64n, updated in the same cycle as the register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| dlvs_i | input | NPINS | Delivery-status level per pin |
| rirr_set_i | input | NPINS | Set awaiting-EOI per pin |
| rirr_clr_i | input | NPINS | Clear awaiting-EOI per pin |
| table_o | output | 64·NPINS | Flat routing table |
| service_o | output | 1 | Pulse after a table write |
| eoi_o | output | 1 | Directed end-of-interrupt strobe |
| eoi_vec_o | output | 8 | Vector carried by the strobe |

## Verification
A corrupted index, identifier or entry shows up at the ports no later than the next window read of that register: rdata_o carries it one cycle after the read. For a table entry it shows even sooner, because table_o exposes the entry in the very cycle after the faulty update. A wrong merge of the status bits, such as an awaiting-EOI flag that survives an edge write, appears on table_o bit 64n+14 one cycle after the write. A misdecoded offset or size appears as a missing or spurious pulse on service_o or eoi_o in the following cycle. The bench's model compares every one of these outputs on every clock, so the first divergent cycle is reported.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] OFS_EOI    = 8'h40;

  localparam logic [7:0] REG_ID  = 8'h00;
  localparam logic [7:0] REG_VER = 8'h01;
  localparam logic [7:0] REG_ARB = 8'h02;
  localparam logic [7:0] REG_TBL = 8'h10;

  localparam int ID_LSB     = 24;
  localparam int ID_W       = 4;
  localparam int MAXENT_LSB = 16;

  localparam int B_DLVS = 12;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;

  localparam logic [63:0] ENT_RW_MASK = 64'hFFFF_0000_0001_AFFF;
  localparam logic [63:0] ENT_RST     = 64'h0000_0000_0001_0000;
  localparam logic [2:0]  FULL_WORD   = 3'd4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_INDEX,
    ACC_WINDOW,
    ACC_EOI
  } acc_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] ofs_i,
  input  logic [2:0] size_i,
  output acc_kind_e  kind_o,
  output logic       any_rd_o,
  output logic       idx_wr_o,
  output logic       win_rd_o,
  output logic       win_wr_o,
  output logic       eoi_wr_o
);
  localparam bit HAS_EOI = (VERSION == 8'h20);

  logic full;

  always_comb begin
    unique case (ofs_i)
      OFS_INDEX:  kind_o = ACC_INDEX;
      OFS_WINDOW: kind_o = ACC_WINDOW;
      OFS_EOI:    kind_o = ACC_EOI;
      default:    kind_o = ACC_NONE;
    endcase
  end

  assign full     = (size_i == FULL_WORD);
  assign any_rd_o = req_i && !we_i;
  assign idx_wr_o = req_i && we_i && (kind_o == ACC_INDEX);
  assign win_rd_o = req_i && !we_i && (kind_o == ACC_WINDOW) && full;
  assign win_wr_o = req_i && we_i && (kind_o == ACC_WINDOW) && full;

  generate
    if (HAS_EOI) begin : g_eoi
      assign eoi_wr_o = req_i && we_i && (kind_o == ACC_EOI) && full;
    end else begin : g_no_eoi
      assign eoi_wr_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        dlvs_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  output logic [63:0] entry_o
);
  logic [63:0] ent_q, merged, ent_d;
  logic        rirr_d;

  always_comb begin
    merged = ent_q;
    if (wr_lo_i) merged[31:0]  = wdata_i;
    if (wr_hi_i) merged[63:32] = wdata_i;
    ent_d  = merged & ENT_RW_MASK;
    // status bits never come from the bus
    rirr_d = (ent_q[B_RIRR] | rirr_set_i) & ~rirr_clr_i;
    if ((wr_lo_i || wr_hi_i) && !ent_d[B_TRIG]) rirr_d = 1'b0;
    ent_d[B_RIRR] = rirr_d;
    ent_d[B_DLVS] = dlvs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= ENT_RST;
    else         ent_q <= ent_d;
  end

  assign entry_o = ent_q;
endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic [7:0]          idx_i,
  input  logic [ID_W-1:0]     id_i,
  input  logic [NPINS*64-1:0] table_i,
  output logic [31:0]         val_o
);
  localparam int TBL_END = int'(REG_TBL) + 2 * NPINS;

  logic [7:0]  rel;
  logic [63:0] sel;
  int          slot;

  always_comb begin
    rel   = idx_i - REG_TBL;
    slot  = int'(rel[7:1]);
    sel   = '0;
    val_o = '0;
    unique case (idx_i)
      REG_ID, REG_ARB: val_o[ID_LSB +: ID_W] = id_i;
      REG_VER: begin
        val_o[7:0]                = VERSION;
        val_o[MAXENT_LSB +: 8]    = 8'(NPINS - 1);
      end
      default: begin
        if (idx_i >= REG_TBL && int'(idx_i) < TBL_END) begin
          sel   = table_i[slot*64 +: 64];
          val_o = idx_i[0] ? sel[63:32] : sel[31:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2:0]          size_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NPINS-1:0]    dlvs_i,
  input  logic [NPINS-1:0]    rirr_set_i,
  input  logic [NPINS-1:0]    rirr_clr_i,
  output logic [NPINS*64-1:0] table_o,
  output logic                service_o,
  output logic                eoi_o,
  output logic [7:0]          eoi_vec_o
);
  localparam int TBL_END = int'(REG_TBL) + 2 * NPINS;

  acc_kind_e        kind;
  logic             any_rd, idx_wr, win_rd, win_wr, eoi_wr;
  logic [7:0]       idx_q;
  logic [ID_W-1:0]  id_q;
  logic [31:0]      win_val, rdata_q;
  logic             svc_q, eoi_q;
  logic [7:0]       eoi_vec_q;
  logic [7:0]       rel;
  logic             tbl_in, tbl_wr;
  logic             unused_hi;

  assign unused_hi = ^addr_i[ADDR_W-1:8];

  irq_route_decode #(.VERSION(VERSION)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .ofs_i    (addr_i[7:0]),
    .size_i   (size_i),
    .kind_o   (kind),
    .any_rd_o (any_rd),
    .idx_wr_o (idx_wr),
    .win_rd_o (win_rd),
    .win_wr_o (win_wr),
    .eoi_wr_o (eoi_wr)
  );

  assign rel    = idx_q - REG_TBL;
  assign tbl_in = (idx_q >= REG_TBL) && (int'(idx_q) < TBL_END);
  assign tbl_wr = win_wr && tbl_in;

  generate
    for (genvar n = 0; n < NPINS; n++) begin : g_ent
      logic hit;
      assign hit = tbl_wr && (rel[7:1] == 7'(n));
      irq_route_entry u_ent (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_lo_i    (hit && !idx_q[0]),
        .wr_hi_i    (hit && idx_q[0]),
        .wdata_i    (wdata_i),
        .dlvs_i     (dlvs_i[n]),
        .rirr_set_i (rirr_set_i[n]),
        .rirr_clr_i (rirr_clr_i[n]),
        .entry_o    (table_o[n*64 +: 64])
      );
    end
  endgenerate

  irq_route_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
    .idx_i   (idx_q),
    .id_i    (id_q),
    .table_i (table_o),
    .val_o   (win_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      id_q  <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata_i[7:0];
      if (win_wr && idx_q == REG_ID) id_q <= wdata_i[ID_LSB +: ID_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      svc_q     <= 1'b0;
      eoi_q     <= 1'b0;
      eoi_vec_q <= '0;
    end else begin
      rdata_q <= '0;
      if (any_rd) begin
        if (kind == ACC_INDEX) rdata_q <= {24'h0, idx_q};
        else if (win_rd)       rdata_q <= win_val;
      end
      svc_q <= tbl_wr;
      eoi_q <= eoi_wr;
      if (eoi_wr) eoi_vec_q <= wdata_i[7:0];
    end
  end

  assign rdata_o   = rdata_q;
  assign service_o = svc_q;
  assign eoi_o     = eoi_q;
  assign eoi_vec_o = eoi_vec_q;
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [2:0]          size_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NPINS-1:0]    rirr_set_i,
  input logic [NPINS-1:0]    rirr_clr_i,
  input logic [NPINS*64-1:0] table_o,
  input logic                service_o,
  input logic                eoi_o,
  input logic [7:0]          eoi_vec_o,
  input logic [7:0]          idx_q
);
  localparam int TBL_END = int'(REG_TBL) + 2 * NPINS;

  logic win_wr_c, tbl_wr_c, eoi_wr_c;
  assign win_wr_c = req_i && we_i && addr_i[7:0] == OFS_WINDOW && size_i == FULL_WORD;
  assign tbl_wr_c = win_wr_c && idx_q >= REG_TBL && int'(idx_q) < TBL_END;
  assign eoi_wr_c = req_i && we_i && addr_i[7:0] == OFS_EOI && size_i == FULL_WORD;

  initial begin
    p_version_legal_r5: assert (VERSION == 8'h11 || VERSION == 8'h20);
  end

  p_eoi_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> $past(eoi_wr_c) && VERSION == 8'h20 && eoi_vec_o == $past(wdata_i[7:0]));

  p_svc_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service_o == $past(tbl_wr_c));

  p_rd_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> rdata_o == 32'h0);

  generate
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      logic wr_n;
      assign wr_n = tbl_wr_c && ((idx_q - REG_TBL) >> 1) == 8'(n);

      p_edge_rirr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_n |=> table_o[n*64+B_TRIG] || !table_o[n*64+B_RIRR]);

      p_rirr_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_n && !rirr_set_i[n] && !rirr_clr_i[n] |=>
          (table_o[n*64+B_TRIG] ? table_o[n*64+B_RIRR] == $past(table_o[n*64+B_RIRR])
                                : !table_o[n*64+B_RIRR]));

      p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        table_o[n*64+17 +: 31] == 31'h0);
    end
  endgenerate
endmodule

bind irq_route_regs irq_route_regs_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .VERSION(VERSION)
) u_chk (.*);

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;
  localparam int NP = 24;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0] size = 3'd4;
  logic [31:0] wdata = '0;
  logic [NP-1:0] dlvs = '0, rset = '0, rclr = '0;

  logic [31:0] rdata, rdata_b;
  logic [NP*64-1:0] tbl, tbl_b;
  logic svc, eoi, svc_b, eoi_b;
  logic [7:0] vec, vec_b;

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  irq_route_regs #(.NPINS(NP), .ADDR_W(AW), .VERSION(8'h20)) u_irq_route_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata), .dlvs_i(dlvs), .rirr_set_i(rset), .rirr_clr_i(rclr),
    .table_o(tbl), .service_o(svc), .eoi_o(eoi), .eoi_vec_o(vec));

  irq_route_regs #(.NPINS(NP), .ADDR_W(AW), .VERSION(8'h11)) u_irq_route_regs_v11 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata_b), .dlvs_i(dlvs), .rirr_set_i(rset), .rirr_clr_i(rclr),
    .table_o(tbl_b), .service_o(svc_b), .eoi_o(eoi_b), .eoi_vec_o(vec_b));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_tbl [NP];
  logic [7:0]  m_idx;
  logic [3:0]  m_id;
  logic [31:0] m_rd;
  logic        m_svc, m_eoi;
  logic [7:0]  m_vec;

  function automatic logic [31:0] m_window(input logic [7:0] i);
    if (i == 8'h00 || i == 8'h02) return {4'h0, m_id, 24'h0};
    if (i == 8'h01) return 32'h0000_0020 | ((NP - 1) << 16);
    if (i >= 8'h10 && int'(i) < 16 + 2 * NP)
      return i[0] ? m_tbl[(i - 16) / 2][63:32] : m_tbl[(i - 16) / 2][31:0];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NP; n++) m_tbl[n] = 64'h1_0000;
      m_idx = 0; m_id = 0; m_rd = 0; m_svc = 0; m_eoi = 0; m_vec = 0;
    end else begin
      logic [63:0] nt [NP];
      logic [7:0] o;
      o = addr[7:0];
      m_rd = 0; m_svc = 0; m_eoi = 0;
      for (int n = 0; n < NP; n++) begin
        nt[n] = m_tbl[n];
        nt[n][14] = (m_tbl[n][14] | rset[n]) & ~rclr[n];
        nt[n][12] = dlvs[n];
      end
      if (req && !we) begin
        if (o == 8'h00) m_rd = {24'h0, m_idx};
        else if (o == 8'h10 && size == 3'd4) m_rd = m_window(m_idx);
      end
      if (req && we) begin
        if (o == 8'h00) m_idx = wdata[7:0];
        else if (o == 8'h10 && size == 3'd4) begin
          if (m_idx == 8'h00) m_id = wdata[27:24];
          else if (m_idx >= 8'h10 && int'(m_idx) < 16 + 2 * NP) begin
            int k;
            logic [63:0] e;
            k = (m_idx - 16) / 2;
            e = m_tbl[k];
            if (m_idx[0]) e[63:32] = wdata; else e[31:0] = wdata;
            e = e & 64'hFFFF_0000_0001_AFFF;
            e[12] = dlvs[k];
            e[14] = e[15] ? nt[k][14] : 1'b0;
            nt[k] = e;
            m_svc = 1;
          end
        end else if (o == 8'h40 && size == 3'd4) begin
          m_eoi = 1; m_vec = wdata[7:0];
        end
      end
      for (int n = 0; n < NP; n++) m_tbl[n] = nt[n];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NP*64-1:0] flat;
      for (int n = 0; n < NP; n++) flat[n*64 +: 64] = m_tbl[n];
      chk({cur_tag, " R12 rdata"}, 64'(rdata), 64'(m_rd));
      chk({cur_tag, " R10 service"}, 64'(svc), 64'(m_svc));
      chk({cur_tag, " R11 eoi"}, 64'(eoi), 64'(m_eoi));
      if (m_eoi) chk({cur_tag, " R11 vec"}, 64'(vec), 64'(m_vec));
      chk({cur_tag, " R13 table"}, 64'(flat == tbl), 64'd1);
      chk("R11 v11 eoi", 64'(eoi_b), 64'd0);
    end
  end

  logic [31:0] r_rd;
  logic r_svc, r_eoi;
  logic [7:0] r_vec;

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [2:0] sz,
                     input logic [31:0] d);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    @(negedge clk);
    r_rd = rdata; r_svc = svc; r_eoi = eoi; r_vec = vec;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic win_rd(input logic [7:0] i);
    acc(1, 12'h000, 3'd4, {24'h0, i});
    acc(0, 12'h010, 3'd4, 32'h0);
  endtask

  task automatic win_wr(input logic [7:0] i, input logic [31:0] d);
    acc(1, 12'h000, 3'd4, {24'h0, i});
    acc(1, 12'h010, 3'd4, d);
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("R1 rdata", 64'(rdata), 64'h0);
    chk("R1 entry0", tbl[63:0], 64'h1_0000);
    chk("R1 entry23", tbl[23*64 +: 64], 64'h1_0000);
    chk("R1 svc/eoi", {62'h0, svc, eoi}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(0, 12'h000, 3'd4, 0); chk("R1 index", 64'(r_rd), 64'h0);
    acc(0, 12'h010, 3'd4, 0); chk("R1 id", 64'(r_rd), 64'h0);

    cur_tag = "R2";
    acc(1, 12'hA00, 3'd1, 32'hFFFF_FF5A);
    acc(0, 12'hF00, 3'd2, 0); chk("R2 index alias", 64'(r_rd), 64'h5A);

    cur_tag = "R5";
    win_rd(8'h01); chk("R5 version", 64'(r_rd), 64'h0017_0020);
    chk("R5 version v11", 64'(rdata_b), 64'h0017_0011);

    cur_tag = "R4";
    win_wr(8'h00, 32'hFFFF_FFFF);
    win_rd(8'h00); chk("R4 id", 64'(r_rd), 64'h0F00_0000);
    win_rd(8'h02); chk("R4 arb", 64'(r_rd), 64'h0F00_0000);
    win_wr(8'h02, 32'h0);
    win_wr(8'h01, 32'h0);
    win_rd(8'h00); chk("R4 arb write ignored", 64'(r_rd), 64'h0F00_0000);
    win_rd(8'h01); chk("R4 ver write ignored", 64'(r_rd), 64'h0017_0020);

    cur_tag = "R3";
    acc(1, 12'h000, 3'd4, 0);
    acc(1, 12'h010, 3'd2, 32'h0);
    acc(0, 12'h010, 3'd2, 0); chk("R3 short read", 64'(r_rd), 64'h0);
    acc(0, 12'h010, 3'd4, 0); chk("R3 short write ignored", 64'(r_rd), 64'h0F00_0000);

    cur_tag = "R6";
    win_wr(8'h10, 32'hFFFF_FFFF); chk("R10 service", 64'(r_svc), 64'h1);
    win_rd(8'h10); chk("R7 low half", 64'(r_rd), 64'h0001_AFFF);
    win_wr(8'h11, 32'hFFFF_FFFF);
    win_rd(8'h11); chk("R7 high half", 64'(r_rd), 64'hFFFF_0000);
    chk("R13 entry0", tbl[63:0], 64'hFFFF_0000_0001_AFFF);
    win_wr(8'h3F, 32'h1234_5678);
    win_rd(8'h3F); chk("R6 last entry", 64'(r_rd), 64'h1234_0000);
    win_wr(8'h40, 32'hFFFF_FFFF); chk("R10 no service out of range", 64'(r_svc), 64'h0);
    win_rd(8'h40); chk("R6 out of range", 64'(r_rd), 64'h0);
    win_rd(8'h05); chk("R6 gap", 64'(r_rd), 64'h0);
    acc(0, 12'h020, 3'd4, 0); chk("R12 unmapped", 64'(r_rd), 64'h0);

    cur_tag = "R8";
    win_wr(8'h16, 32'h0000_8031);
    rset[3] = 1'b1; dlvs[3] = 1'b1;
    @(negedge clk);
    rset[3] = 1'b0;
    win_rd(8'h16); chk("R8 status set", 64'(r_rd), 64'h0000_D031);
    win_wr(8'h16, 32'h0000_8045);
    win_rd(8'h16); chk("R8 status kept", 64'(r_rd), 64'h0000_D045);
    rclr[3] = 1'b1;
    @(negedge clk);
    rclr[3] = 1'b0;
    win_rd(8'h16); chk("R8 status clear", 64'(r_rd), 64'h0000_9045);
    rset[3] = 1'b1;
    @(negedge clk);
    rset[3] = 1'b0;

    cur_tag = "R9";
    win_wr(8'h16, 32'h0000_0045);
    win_rd(8'h16); chk("R9 edge clears", 64'(r_rd), 64'h0000_1045);

    cur_tag = "R11";
    acc(1, 12'h040, 3'd4, 32'h0000_03A7);
    chk("R11 eoi", {55'h0, r_eoi, r_vec}, {55'h0, 1'b1, 8'hA7});
    acc(1, 12'h040, 3'd2, 32'h0000_0011);
    chk("R11 short eoi", 64'(r_eoi), 64'h0);

    cur_tag = "R12";
    @(negedge clk);
    chk("R12 idle rdata", 64'(rdata), 64'h0);
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule